// File: doc/BRIEF.md
# Bouncing Compare-Value Sweep Generator

This block produces two slowly moving compare values for a PWM channel. It counts the ticks of a periodic event, such as the PWM period interrupt. On every eleventh tick it moves each of the two values one unit along a triangle sweep. Each value has its own lower and upper limit and its own starting direction. When a value reaches a limit it turns back, so it bounces between the two limits for as long as ticks arrive.

The two reversal rules are deliberately asymmetric. On the way up, a value turns back once it is no longer below its upper limit. On the way down, it turns back only when it is exactly equal to its lower limit. In both cases the turn and the unit step happen in the same update. The outputs are registered and feed the compare inputs of a downstream PWM timer.

Top module: `sweep_gen`

## Requirements
- R1: While reset is high, each value is reloaded at the next clock edge to its start state. A value that starts moving up (start flag 1) starts at its lower limit. A value that starts moving down (start flag 0) starts at its upper limit. The tick counter is reloaded to 0.
- R2: The tick counter starts at 0. On a tick where the counter equals STEP_GAP (default 10), the counter returns to 0 and an update takes place. On any other tick the counter only increments, so one update occurs per STEP_GAP+1 ticks.
- R3: In a cycle without a tick, both outputs keep their values at the next edge.
- R4: In an update, a value moving up that is below its upper limit increases by 1. A value moving up that is at or above its upper limit turns to moving down and decreases by 1.
- R5: In an update, a value moving down that equals its lower limit turns to moving up and increases by 1. Any other value moving down decreases by 1.
- R6: Both values are updated at the same clock edge. Each uses its own direction and its own limits, so the two values may both reverse in the same update.
- R7: Once reset has been applied, each value stays inside its own limits, inclusive.
- R8: When reset and a tick arrive in the same cycle, reset wins. The tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per periodic event |
| cmp_a | output | CMP_W | Registered compare value A |
| cmp_b | output | CMP_W | Registered compare value B |

## Verification
Two collisions are of interest. The first is when both values reverse in one update. The bench gives A and B sweep spans of equal length and opposite starting directions, so A meets its upper limit in the same update in which B meets its lower limit. A bench model then judges each value separately at that edge. The second collision is a tick arriving in the same cycle as a mid-run reset. In that case the bench expects the start values and a fresh count of eleven ticks before the next step.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    localparam int CMP_W = 16;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } sweep_dir_e;

    typedef struct packed {
        logic [CMP_W-1:0] val;
        sweep_dir_e       dir;
    } lane_t;

    // One unit step with the asymmetric turn rules.
    function automatic lane_t lane_advance(lane_t cur, logic [CMP_W-1:0] lo,
                                           logic [CMP_W-1:0] hi);
        lane_t nxt;
        nxt = cur;
        if (cur.dir == DIR_UP) begin
            if (cur.val < hi) begin
                nxt.val = cur.val + 1'b1;
            end else begin
                nxt.dir = DIR_DOWN;
                nxt.val = cur.val - 1'b1;
            end
        end else begin
            if (cur.val == lo) begin
                nxt.dir = DIR_UP;
                nxt.val = cur.val + 1'b1;
            end else begin
                nxt.val = cur.val - 1'b1;
            end
        end
        return nxt;
    endfunction

    function automatic lane_t lane_start(logic [CMP_W-1:0] lo,
                                         logic [CMP_W-1:0] hi, logic up);
        lane_t s;
        s.dir = up ? DIR_UP : DIR_DOWN;
        s.val = up ? lo : hi;
        return s;
    endfunction

endpackage

// File: rtl/sweep_interval.sv
module sweep_interval #(
    parameter int STEP_GAP = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic step
);
    localparam int CNT_W = $clog2(STEP_GAP + 1) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_GAP);

    logic [CNT_W-1:0] cnt;

    assign step = tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sweep_lane.sv
module sweep_lane
    import sweep_pkg::*;
#(
    parameter int LO       = 50,
    parameter int HI       = 1950,
    parameter bit START_UP = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CMP_W-1:0] val
);
    localparam logic [CMP_W-1:0] LO_V = CMP_W'(LO);
    localparam logic [CMP_W-1:0] HI_V = CMP_W'(HI);

    lane_t st;

    always_ff @(posedge clk) begin
        if (rst)       st <= lane_start(LO_V, HI_V, START_UP);
        else if (step) st <= lane_advance(st, LO_V, HI_V);
    end

    assign val = st.val;
endmodule

// File: rtl/sweep_gen.sv
module sweep_gen
    import sweep_pkg::*;
#(
    parameter int STEP_GAP   = 10,
    parameter int A_MIN      = 50,
    parameter int A_MAX      = 1950,
    parameter bit A_START_UP = 1'b1,
    parameter int B_MIN      = 50,
    parameter int B_MAX      = 1950,
    parameter bit B_START_UP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CMP_W-1:0] cmp_a,
    output logic [CMP_W-1:0] cmp_b
);
    localparam int NLANE = 2;

    logic             step;
    logic [CMP_W-1:0] lane_val [NLANE];

    sweep_interval #(.STEP_GAP(STEP_GAP)) u_interval (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .step(step)
    );

    for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
        localparam int LO_P = (gi == 0) ? A_MIN : B_MIN;
        localparam int HI_P = (gi == 0) ? A_MAX : B_MAX;
        localparam bit UP_P = (gi == 0) ? A_START_UP : B_START_UP;
        sweep_lane #(.LO(LO_P), .HI(HI_P), .START_UP(UP_P)) u_lane (
            .clk (clk),
            .rst (rst),
            .step(step),
            .val (lane_val[gi])
        );
    end

    assign cmp_a = lane_val[0];
    assign cmp_b = lane_val[1];
endmodule

// File: rtl/sweep_gen_chk.sv
module sweep_gen_chk
    import sweep_pkg::*;
#(
    parameter int A_MIN = 50,
    parameter int A_MAX = 1950,
    parameter int B_MIN = 50,
    parameter int B_MAX = 1950
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [CMP_W-1:0] cmp_a,
    input logic [CMP_W-1:0] cmp_b
);
    // R3: no tick, no movement
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(cmp_a) && $stable(cmp_b)));

    // R4 / R5: every move is a single unit
    a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(cmp_a)) |->
            (cmp_a == $past(cmp_a) + 1'b1 || cmp_a == $past(cmp_a) - 1'b1));

    // R6: A and B move at the same edge
    a_r6_joint: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(cmp_a)) |-> !$stable(cmp_b));

    // R7: values stay inside their limits
    a_r7_range_a: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cmp_a >= CMP_W'(A_MIN) && cmp_a <= CMP_W'(A_MAX)));

    a_r7_range_b: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cmp_b >= CMP_W'(B_MIN) && cmp_b <= CMP_W'(B_MAX)));
endmodule

bind sweep_gen sweep_gen_chk #(
    .A_MIN(A_MIN), .A_MAX(A_MAX), .B_MIN(B_MIN), .B_MAX(B_MAX)
) u_sweep_chk (
    .clk(clk), .rst(rst), .tick(tick), .cmp_a(cmp_a), .cmp_b(cmp_b)
);

// File: tb/test_sweep_gen.sv
module test_sweep_gen;
    localparam int GAP  = 10;
    localparam int AMIN = 3,  AMAX = 7;
    localparam int BMIN = 10, BMAX = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [15:0] cmp_a, cmp_b;

    int checks = 0, errors = 0;
    int m_cnt;
    int ma, mb;
    bit da, db;
    string tag;

    always #10 clk = ~clk;

    sweep_gen #(.STEP_GAP(GAP), .A_MIN(AMIN), .A_MAX(AMAX), .A_START_UP(1'b1),
                .B_MIN(BMIN), .B_MAX(BMAX), .B_START_UP(1'b0)) i_sweep_gen (
        .clk(clk), .rst(rst), .tick(tick), .cmp_a(cmp_a), .cmp_b(cmp_b)
    );

    function automatic void bounce(inout int v, inout bit up, input int lo,
                                   input int hi, inout string t);
        if (up) begin
            if (v < hi) v = v + 1;
            else begin up = 0; v = v - 1; t = "R4 turn at upper"; end
        end else begin
            if (v == lo) begin up = 1; v = v + 1; t = "R5 turn at lower"; end
            else v = v - 1;
        end
    endfunction

    task automatic model_reset();
        m_cnt = 0; ma = AMIN; da = 1; mb = BMAX; db = 0;
    endtask

    task automatic drive(input bit t, input bit r);
        string ta, tb2;
        rst = r; tick = t;
        tag = "R3 idle";
        if (r) begin
            model_reset();
            tag = t ? "R8 reset beats tick" : "R1 reset";
        end else if (t) begin
            if (m_cnt == GAP) begin
                m_cnt = 0;
                ta = ""; tb2 = "";
                bounce(ma, da, AMIN, AMAX, ta);
                bounce(mb, db, BMIN, BMAX, tb2);
                if (ta != "" && tb2 != "") tag = "R6 joint turn";
                else if (ta != "") tag = ta;
                else if (tb2 != "") tag = tb2;
                else tag = "R2/R4/R5 step";
            end else begin
                m_cnt++;
                tag = "R2 count only";
            end
        end
        @(negedge clk);
        checks++;
        if (cmp_a !== 16'(ma) || cmp_b !== 16'(mb)) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d expected a=%0d b=%0d",
                     tag, cmp_a, cmp_b, ma, mb);
        end
        checks++;
        if (cmp_a < AMIN || cmp_a > AMAX || cmp_b < BMIN || cmp_b > BMAX) begin
            errors++;
            $display("FAIL R7 range: a=%0d b=%0d expected a in %0d..%0d b in %0d..%0d",
                     cmp_a, cmp_b, AMIN, AMAX, BMIN, BMAX);
        end
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        @(negedge clk);
        drive(0, 1);
        drive(0, 1);
        // R1: start state
        // R2: steady ticks across several full sweeps, joint turns (R6)
        for (int i = 0; i < 400; i++) drive(1, 0);
        // R3: long idle
        for (int i = 0; i < 30; i++) drive(0, 0);
        // random tick pattern
        for (int i = 0; i < 3000; i++) drive(($urandom % 4) != 0, 0);
        // R8: tick coinciding with reset mid-run
        for (int i = 0; i < 7; i++) drive(1, 0);
        drive(1, 1);
        for (int i = 0; i < 60; i++) drive(1, 0);
        for (int i = 0; i < 2000; i++) drive(($urandom % 3) == 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule